// File: doc/BRIEF.md
# Interrupt Cause and Coalescing Controller

This block gathers twelve single-cycle event pulses into a sticky cause register and drives one level interrupt line. Software reads causes and acknowledges them by writing ones. A per-source mask selects which causes may raise the line. A test register sets any single cause by its bit index. Software never reads the mask values themselves from the line.

Two programmable limits throttle the interrupt. One is a count of unmasked events. The other is a number of microsecond ticks since the first unmasked cause became pending. The line rises when either limit is reached. It stays high until no unmasked cause is left, and then both throttling counters start again from zero.

Access is through a 32-bit register port. A 2-bit select picks one of four words: cause (0), mask (1), force (2) and coalesce (3). Writes take effect at the clock edge. Reads are combinational on the select.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the cause word reads 0, the mask word reads 0x00000FFF (every source masked), the coalesce word reads 0x00010001 and irq_o is low.
- R2: A pulse on event_i[b] sets cause bit b. The bits are ordered as follows: 0 response ready, 1 command error, 2 DMA done, 3 DMA error, 4 RNG ready, 5 RNG health, 6 thermal warning, 7 thermal critical, 8 firmware done, 9 firmware error, 10 link down, 11 watchdog.
- R3: Writing the cause word (select 0) clears every cause bit written as 1. Bits written as 0 keep their value.
- R4: If an event on bit b arrives in the same cycle as a write-1-to-clear of bit b, cause bit b stays set.
- R5: Bits 31:12 of the cause and mask words always read zero, and writes to them are ignored.
- R6: A mask bit of 1 keeps its cause from raising irq_o. Clearing the mask bit while the cause is set lets it raise irq_o.
- R7: Writing value p to the force word (select 2) sets cause bit p when p < 12. Larger values change nothing. The force word reads zero.
- R8: In the coalesce word, bits 31:16 are max_count. When max_count is nonzero, irq_o rises one cycle after the number of unmasked events since the counters last restarted reaches max_count.
- R9: In the coalesce word, bits 15:0 are max_usec. When max_usec is nonzero, irq_o rises one cycle after max_usec tick_i pulses have been counted while an unmasked cause was pending.
- R10: When both max_count and max_usec are zero, any pending unmasked cause raises irq_o one cycle after it becomes pending.
- R11: irq_o falls one cycle after no unmasked cause bit remains set. Both throttling counters then restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 cause, 1 mask, 2 force, 3 coalesce |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| event_i | input | 12 | Event pulses, one bit per source |
| tick_i | input | 1 | One-cycle pulse each microsecond |
| irq_o | output | 1 | Coalesced interrupt line |

## Verification
A write or an event lands in the cause, mask or coalesce word at the clock edge it is presented on. So a read selected after that edge shows the new value. The interrupt line is registered from the cause and counter state, so it changes one edge later than that state. The count and tick limits add one edge for each event or tick they take. The bench drives all inputs and samples all outputs on falling edges. It counts exactly that many falling edges after each stimulus before it compares, and it also checks that the line is still low one edge earlier.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned NUM_SRC  = 12;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned LIM_W    = 16;
  localparam logic [31:0] COAL_RST = 32'h0001_0001;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_FORCE = 2'd2,
    SEL_COAL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_cfg_regs.sv
module evt_cfg_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned LW    = LIM_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  reg_sel_e        sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [N_SRC-1:0] mask_o,
  output logic [LW-1:0]   max_usec_o,
  output logic [LW-1:0]   max_cnt_o
);
  localparam logic [LW-1:0] USEC_RST = COAL_RST[LW-1:0];
  localparam logic [LW-1:0] CNT_RST  = COAL_RST[2*LW-1:LW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '1;
      max_usec_o <= USEC_RST;
      max_cnt_o  <= CNT_RST;
    end else if (wr_en_i) begin
      if (sel_i == SEL_MASK) mask_o <= wdata_i[N_SRC-1:0];
      if (sel_i == SEL_COAL) begin
        max_usec_o <= wdata_i[LW-1:0];
        max_cnt_o  <= wdata_i[2*LW-1:LW];
      end
    end
  end
endmodule

// File: rtl/evt_cause_reg.sv
module evt_cause_reg
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned DW    = DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0] event_i,
  output logic [N_SRC-1:0] force_o,
  output logic [N_SRC-1:0] cause_o
);
  logic clr_wr, frc_wr;
  assign clr_wr = wr_en_i && (sel_i == SEL_CAUSE);
  assign frc_wr = wr_en_i && (sel_i == SEL_FORCE);

  for (genvar b = 0; b < N_SRC; b++) begin : g_bit
    logic clr_b;
    assign force_o[b] = frc_wr && (wdata_i == DW'(b));
    assign clr_b      = clr_wr && wdata_i[b];

    // new event wins over an acknowledge in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cause_o[b] <= 1'b0;
      else if (event_i[b] || force_o[b]) cause_o[b] <= 1'b1;
      else if (clr_b)                  cause_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_coalesce.sv
module evt_coalesce
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned LW    = LIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] event_i,
  input  logic [N_SRC-1:0] force_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic [N_SRC-1:0] cause_i,
  input  logic             tick_i,
  input  logic [LW-1:0]    max_cnt_i,
  input  logic [LW-1:0]    max_usec_i,
  output logic             pending_o,
  output logic             irq_o
);
  localparam int unsigned IW = $clog2(N_SRC + 1);

  logic [N_SRC-1:0] new_evt;
  logic [IW-1:0]    inc;
  logic [LW-1:0]    cnt_q, cnt_d, cnt_base, tmr_q, tmr_d;
  logic [LW:0]      cnt_sum;
  logic             cnt_hit, tmr_hit, both_off, irq_d;

  assign pending_o = |(cause_i & ~mask_i);
  assign new_evt   = (event_i | force_i) & ~mask_i;

  always_comb begin
    inc = '0;
    for (int i = 0; i < N_SRC; i++) inc = inc + IW'(new_evt[i]);
  end

  assign cnt_base = pending_o ? cnt_q : '0;
  assign cnt_sum  = {1'b0, cnt_base} + (LW + 1)'(inc);
  assign cnt_d    = cnt_sum[LW] ? '1 : cnt_sum[LW-1:0];

  always_comb begin
    tmr_d = tmr_q;
    if (!pending_o)                           tmr_d = '0;
    else if (tick_i && !irq_o && tmr_q != '1) tmr_d = tmr_q + 1'b1;
  end

  assign cnt_hit  = (max_cnt_i != '0) && (cnt_q >= max_cnt_i);
  assign tmr_hit  = (max_usec_i != '0) && (tmr_q >= max_usec_i);
  assign both_off = (max_cnt_i == '0) && (max_usec_i == '0);
  assign irq_d    = pending_o && (irq_o || cnt_hit || tmr_hit || both_off);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmr_q <= '0;
      irq_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tmr_q <= tmr_d;
      irq_o <= irq_d;
    end
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned LW    = LIM_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [N_SRC-1:0] event_i,
  input  logic             tick_i,
  output logic             irq_o
);
  reg_sel_e         sel;
  logic [N_SRC-1:0] mask, cause, force_vec;
  logic [LW-1:0]    max_usec, max_cnt;
  logic             pending;

  assign sel = reg_sel_e'(addr_i);

  evt_cfg_regs #(.N_SRC(N_SRC), .DW(DW), .LW(LW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .mask_o     (mask),
    .max_usec_o (max_usec),
    .max_cnt_o  (max_cnt)
  );

  evt_cause_reg #(.N_SRC(N_SRC), .DW(DW)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .event_i (event_i),
    .force_o (force_vec),
    .cause_o (cause)
  );

  evt_coalesce #(.N_SRC(N_SRC), .LW(LW)) u_coal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (event_i),
    .force_i    (force_vec),
    .mask_i     (mask),
    .cause_i    (cause),
    .tick_i     (tick_i),
    .max_cnt_i  (max_cnt),
    .max_usec_i (max_usec),
    .pending_o  (pending),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CAUSE: rdata_o[N_SRC-1:0] = cause;
      SEL_MASK:  rdata_o[N_SRC-1:0] = mask;
      SEL_FORCE: rdata_o = '0;
      SEL_COAL:  rdata_o[2*LW-1:0] = {max_cnt, max_usec};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned N_SRC = 12,
  parameter int unsigned DW    = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic [N_SRC-1:0] event_i,
  input logic             irq_o,
  input logic [N_SRC-1:0] cause,
  input logic [N_SRC-1:0] mask,
  input logic             pending
);
  localparam int unsigned PW = $clog2(N_SRC);

  // events always latch, even under an acknowledge (R2, R4)
  p_event_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((cause & $past(event_i)) == $past(event_i)));

  p_w1c_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=>
      ((cause & $past(wdata_i[N_SRC-1:0] & ~event_i)) == '0));

  p_rsvd_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0 || addr_i == 2'd1) |-> (rdata_o[DW-1:N_SRC] == '0));

  p_force_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2 && wdata_i < DW'(N_SRC)) |=>
      (((cause >> $past(wdata_i[PW-1:0])) & N_SRC'(1)) == N_SRC'(1)));

  p_irq_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending |=> !irq_o);

  p_mask_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause & ~mask) == '0) |=> !irq_o);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.N_SRC(N_SRC), .DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .event_i (event_i),
  .irq_o   (irq_o),
  .cause   (cause),
  .mask    (mask),
  .pending (pending)
);

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] evt = '0;
  logic        tick = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(evt), .tick_i(tick), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [11:0] b);
    @(negedge clk); evt = b;
    @(negedge clk); evt = '0;
  endtask

  task automatic one_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanup();
    wr(2'd1, 32'h0000_0FFF);
    wr(2'd0, 32'h0000_0FFF);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); check("R1 cause", d, 32'h0);
    rd(2'd1, d); check("R1 mask", d, 32'h0000_0FFF);
    rd(2'd3, d); check("R1 coalesce", d, 32'h0001_0001);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    for (int b = 0; b < 12; b++) begin
      pulse(12'(1 << b));
      rd(2'd0, d); check("R2 capture", d, 32'(1 << b));
      wr(2'd0, 32'h0000_0FFF);
    end
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(12'h0A5);
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, d); check("R3 clear ones", d, 32'h0000_00A0);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R3 zeros keep", d, 32'h0000_00A0);
    wr(2'd0, 32'h0000_0FFF);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 32'h0000_0080; evt = 12'h080;
    @(negedge clk); wr_en = 1'b0; wdata = '0; evt = '0;
    rd(2'd0, d); check("R4 event beats clear", d, 32'h0000_0080);
    wr(2'd0, 32'h0000_0FFF);
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R5 mask upper", d, 32'h0000_0FFF);
    pulse(12'hFFF);
    wr(2'd0, 32'hFFFF_F000);
    rd(2'd0, d); check("R5 cause upper write ignored", d, 32'h0000_0FFF);
    wr(2'd0, 32'h0000_0FFF);
  endtask

  task automatic t_mask();
    wr(2'd3, 32'h0);
    pulse(12'h008);
    idle(3);
    check("R6 masked holds low", {31'h0, irq}, 32'h0);
    wr(2'd1, 32'h0000_0FF7);
    check("R6 unmask not yet", {31'h0, irq}, 32'h0);
    idle(1);
    check("R6 unmask raises", {31'h0, irq}, 32'h1);
    cleanup();
  endtask

  task automatic t_force();
    logic [31:0] d;
    wr(2'd2, 32'd5);
    rd(2'd0, d); check("R7 force 5", d, 32'h0000_0020);
    wr(2'd2, 32'd12);
    wr(2'd2, 32'd31);
    wr(2'd2, 32'h0000_0100);
    rd(2'd0, d); check("R7 out of range ignored", d, 32'h0000_0020);
    rd(2'd2, d); check("R7 force reads zero", d, 32'h0);
    wr(2'd0, 32'h0000_0FFF);
  endtask

  task automatic t_count();
    wr(2'd3, 32'h0003_0000);
    wr(2'd1, 32'h0);
    pulse(12'h001); idle(1);
    check("R8 after 1", {31'h0, irq}, 32'h0);
    pulse(12'h004); idle(1);
    check("R8 after 2", {31'h0, irq}, 32'h0);
    pulse(12'h004);
    check("R8 edge before", {31'h0, irq}, 32'h0);
    idle(1);
    check("R8 count reached", {31'h0, irq}, 32'h1);
    cleanup();
  endtask

  task automatic t_timer();
    wr(2'd3, 32'h0000_0003);
    wr(2'd1, 32'h0);
    pulse(12'h200);
    idle(5);
    check("R9 no ticks", {31'h0, irq}, 32'h0);
    one_tick(); one_tick();
    idle(2);
    check("R9 two ticks", {31'h0, irq}, 32'h0);
    one_tick();
    check("R9 edge before", {31'h0, irq}, 32'h0);
    idle(1);
    check("R9 ticks reached", {31'h0, irq}, 32'h1);
    cleanup();
  endtask

  task automatic t_zero();
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h0);
    pulse(12'h800);
    check("R10 edge before", {31'h0, irq}, 32'h0);
    idle(1);
    check("R10 immediate", {31'h0, irq}, 32'h1);
    cleanup();
  endtask

  task automatic t_deassert();
    wr(2'd3, 32'h0002_0000);
    wr(2'd1, 32'h0);
    pulse(12'h001); pulse(12'h002); idle(1);
    check("R11 setup raised", {31'h0, irq}, 32'h1);
    pulse(12'h004);
    wr(2'd0, 32'h0000_0003);
    idle(2);
    check("R11 still pending", {31'h0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0004);
    check("R11 one edge later", {31'h0, irq}, 32'h1);
    idle(1);
    check("R11 falls", {31'h0, irq}, 32'h0);
    pulse(12'h010); idle(3);
    check("R11 counter restarted", {31'h0, irq}, 32'h0);
    pulse(12'h010); idle(1);
    check("R11 second event raises", {31'h0, irq}, 32'h1);
    cleanup();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_capture();
    t_w1c();
    t_rsvd();
    t_mask();
    t_force();
    t_count();
    t_timer();
    t_zero();
    t_deassert();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule